// File: doc/BRIEF.md
# Vectored Interrupt Pending/Active Tracker

The tracker holds the bookkeeping for a bank of external interrupt lines in front of a processor core. Each line carries a pending flag, an enable flag, an active flag and a small programmable priority. Together the pending and active flags give each line one of four conditions: idle, waiting, in service, or in service with a further request latched. On every cycle the tracker looks at the lines that are pending and enabled but not already in service. It picks the most urgent of them. When that line beats the priority of the code now running, the tracker takes it.

A take is reported as a one-cycle entry pulse carrying the vector number (line plus 16). In the same clock edge the line's pending flag is cleared, its active flag is set, and the line is pushed onto an internal nesting stack. A return pulse from the core pops the most recently taken line and clears its active flag. The core then runs again at the priority of the line below it on the stack, or at thread level. Requests arrive as per-line hardware pulses or as write-one-to-set word writes. One write port carries the set-pending writes, the set-enable writes and the per-line priority writes.

Top module: `vic_tracker`

## Requirements
- R1: After reset every line is idle and disabled: `line_pending`, `line_enabled` and `line_active` are all zero, `nest_depth` and `cur_vector` are 0, and `entry_pulse` is low.
- R2: A write with `wr_op`=0 (set-pending) or `wr_op`=1 (set-enable) to word index `wr_idx`=w sets the flag of line 32*w+b for each one bit b of `wr_data` at the clock edge. Zero bits leave the flags unchanged, so line 39 is bit 7 of word 1.
- R3: A high `irq_pulse[n]` during a clock edge sets the pending flag of line n.
- R4: Only a line that is both pending and enabled is taken. A line made pending while disabled stays pending and is taken on the clock edge after the edge that enables it.
- R5: A take raises `entry_pulse` for one cycle, on the edge after the line became eligible, with `entry_vector` = 16 + line. On that same edge the line's pending flag clears, its active flag sets, `nest_depth` rises by one and `cur_vector` becomes the new vector.
- R6: Among eligible lines the lowest priority value wins, and on equal values the lower line number wins.
- R7: A line preempts the line in service only if its priority value is strictly lower than that line's. An equal or higher value waits until the return, and from thread level any eligible line is taken.
- R8: A request for a line already in service leaves it active and pending. The line is not taken again until its return, and it is taken on the edge after that return.
- R9: A `ret_pulse` clears the active flag of the most recently taken line, lowers `nest_depth` by one and restores `cur_vector` to the vector below it (0 at thread level). No take happens on a return edge, and a return with `nest_depth` 0 has no effect.
- R10: At most 8 lines are nested. With `nest_depth` 8 no further take occurs, and a waiting more urgent line is taken on the edge after a return frees a level.
- R11: A write with `wr_op`=2 sets the priority of line `wr_idx` to `wr_data[3:0]`. All priorities reset to 0, and `wr_op`=3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pulse | input | 64 | Per-line hardware request pulses |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 2 | 0 set-pending word, 1 set-enable word, 2 line priority |
| wr_idx | input | 6 | Word index (ops 0, 1) or line number (op 2) |
| wr_data | input | 32 | Write data |
| ret_pulse | input | 1 | Handler return from the core |
| entry_pulse | output | 1 | One-cycle take indication |
| entry_vector | output | 7 | Vector number of the take |
| cur_vector | output | 7 | Vector now in service, 0 at thread level |
| nest_depth | output | 4 | Number of nested lines in service |
| line_pending | output | 64 | Pending flag per line |
| line_enabled | output | 64 | Enable flag per line |
| line_active | output | 64 | Active flag per line |

## Verification
The case that is hardest to reach is a full nesting stack with a more urgent line left waiting. Reaching it needs nine lines whose priorities fall strictly one after another. The stimulus gives lines 0 to 8 the values 8 down to 0 and raises them one at a time, so each one preempts the last until eight are nested. The ninth then has to wait until a single return lets it in. The retrigger case is reached by pulsing a line while its own handler is in service and holding off the return for several cycles. A sweep over line pairs and all priority combinations checks both the winner and the loser, which must be served later.

// File: rtl/vic_tracker.sv
module vic_tracker #(
  parameter int NUM_LINES   = 64,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 8,
  parameter int WORD_W      = 32,
  parameter int VEC_BASE    = 16,
  localparam int LINE_W     = $clog2(NUM_LINES),
  localparam int VEC_W      = $clog2(NUM_LINES + VEC_BASE),
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_pulse,
  input  logic                 wr_en,
  input  logic [1:0]           wr_op,
  input  logic [LINE_W-1:0]    wr_idx,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 ret_pulse,
  output logic                 entry_pulse,
  output logic [VEC_W-1:0]     entry_vector,
  output logic [VEC_W-1:0]     cur_vector,
  output logic [DEPTH_W-1:0]   nest_depth,
  output logic [NUM_LINES-1:0] line_pending,
  output logic [NUM_LINES-1:0] line_enabled,
  output logic [NUM_LINES-1:0] line_active
);
  localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;
  localparam int SIDX_W    = $clog2(STACK_DEPTH);
  localparam logic [1:0] OP_PEND = 2'd0;
  localparam logic [1:0] OP_ENAB = 2'd1;
  localparam logic [1:0] OP_PRIO = 2'd2;

  logic [NUM_LINES-1:0] pend_q, en_q, act_q;
  logic [PRIO_W-1:0]    prio_q    [NUM_LINES];
  logic [LINE_W-1:0]    stk_line  [STACK_DEPTH];
  logic [PRIO_W-1:0]    stk_prio  [STACK_DEPTH];
  logic [DEPTH_W-1:0]   depth_q;

  logic [PAD_W-1:0] sw_pend_set, sw_en_set;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == LINE_W'(w));
    assign sw_pend_set[w*WORD_W +: WORD_W] = (hit && wr_op == OP_PEND) ? wr_data : '0;
    assign sw_en_set[w*WORD_W +: WORD_W]   = (hit && wr_op == OP_ENAB) ? wr_data : '0;
  end

  logic [NUM_LINES-1:0] cand;
  logic                 found;
  logic [LINE_W-1:0]    best_line;
  logic [PRIO_W-1:0]    best_prio;

  assign cand = pend_q & en_q & ~act_q;

  always_comb begin
    found     = 1'b0;
    best_line = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!found || prio_q[i] < best_prio)) begin
        found     = 1'b1;
        best_line = LINE_W'(i);
        best_prio = prio_q[i];
      end
    end
  end

  logic [SIDX_W-1:0] top_idx, push_idx;
  logic              stack_empty, stack_full;
  logic [PRIO_W:0]   exec_prio;
  logic              take_fire, pop_fire;

  assign stack_empty = (depth_q == '0);
  assign stack_full  = (depth_q == DEPTH_W'(STACK_DEPTH));
  assign top_idx     = SIDX_W'(depth_q - DEPTH_W'(1));
  assign push_idx    = SIDX_W'(depth_q);
  assign exec_prio   = stack_empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, stk_prio[top_idx]};
  assign take_fire   = found && !ret_pulse && !stack_full && ({1'b0, best_prio} < exec_prio);
  assign pop_fire    = ret_pulse && !stack_empty;

  logic [NUM_LINES-1:0] take_mask, pop_mask;
  assign take_mask = take_fire ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << best_line) : '0;
  assign pop_mask  = pop_fire  ? ({{(NUM_LINES-1){1'b0}}, 1'b1} << stk_line[top_idx]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_mask) | irq_pulse | sw_pend_set[NUM_LINES-1:0];
      en_q   <= en_q | sw_en_set[NUM_LINES-1:0];
      act_q  <= (act_q & ~pop_mask) | take_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= '0;
    end else if (wr_en && wr_op == OP_PRIO) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (wr_idx == LINE_W'(i)) prio_q[i] <= wr_data[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      for (int i = 0; i < STACK_DEPTH; i++) begin
        stk_line[i] <= '0;
        stk_prio[i] <= '0;
      end
    end else if (take_fire) begin
      stk_line[push_idx] <= best_line;
      stk_prio[push_idx] <= best_prio;
      depth_q            <= depth_q + DEPTH_W'(1);
    end else if (pop_fire) begin
      depth_q <= depth_q - DEPTH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_pulse  <= 1'b0;
      entry_vector <= '0;
    end else begin
      entry_pulse <= take_fire;
      if (take_fire) entry_vector <= VEC_W'(VEC_BASE) + VEC_W'(best_line);
    end
  end

  assign cur_vector   = stack_empty ? '0 : VEC_W'(VEC_BASE) + VEC_W'(stk_line[top_idx]);
  assign nest_depth   = depth_q;
  assign line_pending = pend_q;
  assign line_enabled = en_q;
  assign line_active  = act_q;
endmodule

// File: rtl/vic_tracker_checker.sv
module vic_tracker_checker #(
  parameter int NUM_LINES   = 64,
  parameter int STACK_DEPTH = 8,
  parameter int VEC_BASE    = 16,
  localparam int LINE_W     = $clog2(NUM_LINES),
  localparam int VEC_W      = $clog2(NUM_LINES + VEC_BASE),
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ret_pulse,
  input logic                 entry_pulse,
  input logic [VEC_W-1:0]     entry_vector,
  input logic [VEC_W-1:0]     cur_vector,
  input logic [DEPTH_W-1:0]   nest_depth,
  input logic [NUM_LINES-1:0] line_pending,
  input logic [NUM_LINES-1:0] line_enabled,
  input logic [NUM_LINES-1:0] line_active
);
  logic [NUM_LINES-1:0] pend_seen;
  logic [LINE_W-1:0]    entry_line;

  assign entry_line = LINE_W'(entry_vector - VEC_W'(VEC_BASE));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_seen <= '0;
    else        pend_seen <= line_pending;

  AST_TAKE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> pend_seen[entry_line] && line_enabled[entry_line]); // R4

  AST_TAKE_MARKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> line_active[entry_line] && cur_vector == entry_vector); // R5

  AST_TAKE_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    entry_pulse |-> nest_depth == $past(nest_depth) + DEPTH_W'(1)); // R5

  AST_ACTIVE_MATCHES_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(line_active) == 32'(nest_depth)); // R9

  AST_RETURN_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && nest_depth != '0 |=> nest_depth == $past(nest_depth) - DEPTH_W'(1)); // R9

  AST_EMPTY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && nest_depth == '0 |=> nest_depth == '0); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= DEPTH_W'(STACK_DEPTH)); // R10
endmodule

bind vic_tracker vic_tracker_checker #(
  .NUM_LINES(NUM_LINES), .STACK_DEPTH(STACK_DEPTH), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_pulse(ret_pulse),
  .entry_pulse(entry_pulse), .entry_vector(entry_vector), .cur_vector(cur_vector),
  .nest_depth(nest_depth), .line_pending(line_pending),
  .line_enabled(line_enabled), .line_active(line_active)
);

// File: tb/test_vic_tracker.sv
module test_vic_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_pulse = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_op = '0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        ret_pulse = 1'b0;
  logic        entry_pulse;
  logic [6:0]  entry_vector, cur_vector;
  logic [3:0]  nest_depth;
  logic [63:0] line_pending, line_enabled, line_active;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_tracker i_vic_tracker (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .wr_en(wr_en), .wr_op(wr_op),
    .wr_idx(wr_idx), .wr_data(wr_data), .ret_pulse(ret_pulse),
    .entry_pulse(entry_pulse), .entry_vector(entry_vector), .cur_vector(cur_vector),
    .nest_depth(nest_depth), .line_pending(line_pending),
    .line_enabled(line_enabled), .line_active(line_active)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] op, input int idx, input logic [31:0] data);
    wr_en = 1'b1; wr_op = op; wr_idx = 6'(idx); wr_data = data;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [63:0] m);
    irq_pulse = m;
    tick();
    irq_pulse = '0;
  endtask

  task automatic ret();
    ret_pulse = 1'b1;
    tick();
    ret_pulse = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic enable_all();
    wr(2'd1, 0, 32'hffff_ffff);
    wr(2'd1, 1, 32'hffff_ffff);
  endtask

  function automatic logic [63:0] bit_of(input int n);
    return 64'd1 << n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 pending", line_pending, 64'd0);
    check("R1 enabled", line_enabled, 64'd0);
    check("R1 active", line_active, 64'd0);
    check("R1 depth", 64'(nest_depth), 0);
    check("R1 cur_vector", 64'(cur_vector), 0);
    check("R1 entry", 64'(entry_pulse), 0);

    for (int l = 0; l < 64; l++) begin
      wr(2'd1, l / 32, 32'd1 << (l % 32));
      check("R2 enable accumulate", line_enabled, (l == 63) ? '1 : (bit_of(l + 1) - 64'd1));
      wr(2'd0, l / 32, 32'd1 << (l % 32));
      check("R2 pending set", line_pending, bit_of(l));
      check("R5 no early entry", 64'(entry_pulse), 0);
      tick();
      check("R5 entry pulse", 64'(entry_pulse), 1);
      check("R5 entry vector", 64'(entry_vector), 64'(16 + l));
      check("R5 pending cleared", line_pending, 64'd0);
      check("R5 active set", line_active, bit_of(l));
      check("R5 cur_vector", 64'(cur_vector), 64'(16 + l));
      check("R5 depth", 64'(nest_depth), 1);
      ret();
      check("R5 single pulse", 64'(entry_pulse), 0);
      check("R9 active cleared", line_active, 64'd0);
      check("R9 depth", 64'(nest_depth), 0);
      check("R9 cur_vector", 64'(cur_vector), 0);
    end

    for (int l = 0; l < 64; l++) begin
      pulse(bit_of(l));
      check("R3 hw pending", line_pending, bit_of(l));
      tick();
      check("R3 hw entry vector", 64'(entry_vector), 64'(16 + l));
      check("R3 hw entry pulse", 64'(entry_pulse), 1);
      ret();
    end

    do_reset();
    wr(2'd0, 1, 32'h80);
    repeat (3) tick();
    check("R4 disabled waits", line_pending, bit_of(39));
    check("R4 disabled no entry", 64'(entry_pulse), 0);
    check("R4 disabled depth", 64'(nest_depth), 0);
    wr(2'd3, 1, 32'h80);
    check("R11 op3 ignored", line_enabled, 64'd0);
    wr(2'd1, 1, 32'h80);
    check("R4 enable edge", 64'(entry_pulse), 0);
    tick();
    check("R4 late enable entry", 64'(entry_vector), 64'd55);
    check("R4 late enable pulse", 64'(entry_pulse), 1);
    ret();

    do_reset();
    enable_all();
    for (int p = 0; p < 4; p++) begin
      int a, b;
      case (p)
        0: begin a = 3;  b = 40; end
        1: begin a = 41; b = 2;  end
        2: begin a = 17; b = 18; end
        default: begin a = 63; b = 0; end
      endcase
      for (int pa = 0; pa < 16; pa++) begin
        for (int pb = 0; pb < 16; pb++) begin
          int win, lose;
          wr(2'd2, a, 32'(pa));
          wr(2'd2, b, 32'(pb));
          win  = (pa < pb || (pa == pb && a < b)) ? a : b;
          lose = (win == a) ? b : a;
          pulse(bit_of(a) | bit_of(b));
          tick();
          check("R6 R11 winner", 64'(entry_vector), 64'(16 + win));
          check("R7 loser waits", line_pending, bit_of(lose));
          ret();
          check("R7 no take on return", 64'(entry_pulse), 0);
          tick();
          check("R6 loser after return", 64'(entry_vector), 64'(16 + lose));
          check("R6 loser pulse", 64'(entry_pulse), 1);
          ret();
        end
      end
    end

    do_reset();
    enable_all();
    wr(2'd2, 10, 5);
    wr(2'd2, 20, 3);
    wr(2'd2, 30, 5);
    pulse(bit_of(10));
    tick();
    check("R7 first entry", 64'(entry_vector), 64'd26);
    pulse(bit_of(30));
    repeat (3) tick();
    check("R7 equal waits depth", 64'(nest_depth), 1);
    check("R7 equal waits pending", line_pending, bit_of(30));
    check("R7 equal waits cur", 64'(cur_vector), 64'd26);
    pulse(bit_of(20));
    tick();
    check("R7 preempt vector", 64'(entry_vector), 64'd36);
    check("R7 preempt depth", 64'(nest_depth), 2);
    check("R7 both active", line_active, bit_of(10) | bit_of(20));
    ret();
    check("R9 restore cur", 64'(cur_vector), 64'd26);
    check("R9 restore depth", 64'(nest_depth), 1);
    tick();
    check("R7 equal still waits", 64'(entry_pulse), 0);
    ret();
    tick();
    check("R7 equal after return", 64'(entry_vector), 64'd46);
    ret();

    do_reset();
    enable_all();
    pulse(bit_of(12));
    tick();
    check("R8 first entry", 64'(entry_vector), 64'd28);
    pulse(bit_of(12));
    check("R8 active and pending a", line_active, bit_of(12));
    check("R8 active and pending p", line_pending, bit_of(12));
    repeat (4) tick();
    check("R8 not re-entered", 64'(entry_pulse), 0);
    check("R8 depth", 64'(nest_depth), 1);
    ret();
    check("R8 after return active", line_active, 64'd0);
    check("R8 after return pending", line_pending, bit_of(12));
    tick();
    check("R8 retaken", 64'(entry_vector), 64'd28);
    check("R8 retaken pulse", 64'(entry_pulse), 1);
    ret();

    do_reset();
    ret();
    check("R9 empty return depth", 64'(nest_depth), 0);
    check("R9 empty return cur", 64'(cur_vector), 0);
    check("R9 empty return active", line_active, 64'd0);

    do_reset();
    enable_all();
    for (int i = 0; i < 9; i++) wr(2'd2, i, 32'(8 - i));
    for (int i = 0; i < 8; i++) begin
      pulse(bit_of(i));
      tick();
      check("R10 nest entry", 64'(entry_vector), 64'(16 + i));
      check("R10 nest depth", 64'(nest_depth), 64'(i + 1));
    end
    pulse(bit_of(8));
    repeat (3) tick();
    check("R10 full no entry", 64'(entry_pulse), 0);
    check("R10 full depth", 64'(nest_depth), 8);
    check("R10 full pending", line_pending, bit_of(8));
    ret();
    tick();
    check("R10 freed entry", 64'(entry_vector), 64'd24);
    check("R10 freed depth", 64'(nest_depth), 8);
    for (int i = 0; i < 8; i++) ret();
    check("R10 unwound depth", 64'(nest_depth), 0);
    check("R10 unwound active", line_active, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule